// File: doc/BRIEF.md
# Row-Parallel Block Difference Accumulator

This block is the arithmetic core of a motion-estimation search. It measures how far a candidate reference block is from the current block by summing the absolute pixel differences. Each accepted issue carries one row from each block: sixteen unsigned 8-bit pixels packed into a 128-bit word. In every lane the block subtracts the reference pixel from the current pixel, takes the magnitude of that difference, and adds the sixteen magnitudes together. The row total then goes into a running accumulator. A 16x16 block therefore needs sixteen issues.

A block begins with an issue that has `in_start` set. That issue also carries the number of rows in the block. The per-row adder tree ends in one register stage, and the accumulator follows it. When the last row's total reaches the accumulator, `done` pulses for one cycle and `sad_total` holds the block's sum. The input handshake then stays closed until the consumer acknowledges the result with `res_ack`, so no new issue can start while a finished result is still unread.

Top module: `sad_row_engine`

## Requirements
- R1: Each lane i occupies bits [8i+7:8i] of both operands, and its pixels are unsigned. The lane contributes |cur − ref|, computed exactly. The magnitude ranges from 0 to 255 whichever operand is larger.
- R2: An accepted row adds the sum of its sixteen lane magnitudes (0 to 4080) to the block total.
- R3: An accepted row with `in_start` high starts a new total equal to that row's sum alone. Nothing from any earlier total is carried into it.
- R4: Each later accepted row of an open block adds its sum to the running total. A block of 16 rows of 255-vs-0 pixels yields 65280 with no wrap.
- R5: The row count is taken from `in_rows` (an unsigned 5-bit value) on the start issue only. A value of 0 is treated as 1, and any value above 16 is treated as 16.
- R6: `done` is high for exactly one cycle, after the second rising edge that follows acceptance of the block's last row. In that same cycle `sad_total` shows the block sum, and it keeps that value until the next block's first row reaches the accumulator.
- R7: `in_ready` is low from the edge that accepts the last row until the first edge at which `res_ack` is high while a result is pending. It is high again in the cycle after that edge.
- R8: An accepted row without `in_start` while no block is open has no effect. `sad_total` is unchanged and no `done` follows.
- R9: A start issue that arrives while a block is open abandons the open block. That block never produces `done`, and only the new block's rows count.
- R10: After reset, `in_ready` is 1, `done` is 0 and `sad_total` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An issue is offered this cycle |
| in_ready | output | 1 | The engine accepts the offered issue |
| in_start | input | 1 | The issue is the first row of a new block |
| in_rows | input | 5 | Rows in the block, sampled with `in_start` |
| in_cur | input | 128 | Sixteen current-block pixels, lane i at [8i+7:8i] |
| in_ref | input | 128 | Sixteen reference-block pixels, same layout |
| res_ack | input | 1 | The consumer has taken the finished result |
| done | output | 1 | One-cycle pulse: the block sum is final |
| sad_total | output | 16 | Running and then final block sum |

## Verification
An issue is accepted at a rising edge where `in_valid` and `in_ready` are both high. Its row total is registered at that edge and reaches the accumulator at the next one. So `done` and the final `sad_total` appear after the second edge following the last row, while `in_ready` falls right after the accepting edge and comes back one edge after an acknowledge. The bench drives and samples on falling edges. It counts edges from each acceptance and checks `done`, `sad_total` and `in_ready` only in the cycles where each is due. Expected block sums wait in a queue and are compared each time `done` is seen, and a `done` that arrives with nothing queued is reported as a failure.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int LANES     = 16;
    localparam int PIX_W     = 8;
    localparam int MAX_ROWS  = 16;
    localparam int ROW_SUM_W = PIX_W + $clog2(LANES);
    localparam int ACC_W     = ROW_SUM_W + $clog2(MAX_ROWS);
    localparam int CNT_W     = $clog2(MAX_ROWS + 1);
    localparam int BUS_W     = LANES * PIX_W;

    // Tag travelling with a kept row through the tree register.
    typedef struct packed {
        logic opens;
        logic closes;
    } row_tag_t;

    // Map the requested row count into the legal range 1..MAX_ROWS.
    function automatic logic [CNT_W-1:0] legal_rows(input logic [CNT_W-1:0] req);
        if (req == '0)
            return CNT_W'(1);
        else if (req > CNT_W'(MAX_ROWS))
            return CNT_W'(MAX_ROWS);
        else
            return req;
    endfunction

endpackage

// File: rtl/sad_lane_absdiff.sv
module sad_lane_absdiff #(
    parameter int LANES = sad_pkg::LANES,
    parameter int PIX_W = sad_pkg::PIX_W
) (
    input  logic [LANES*PIX_W-1:0] cur_px,
    input  logic [LANES*PIX_W-1:0] ref_px,
    output logic [LANES*PIX_W-1:0] mag_px
);

    localparam int DW = PIX_W + 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [DW-1:0] diff;
        logic        [DW-1:0] pos;

        assign diff = $signed({1'b0, cur_px[i*PIX_W +: PIX_W]})
                    - $signed({1'b0, ref_px[i*PIX_W +: PIX_W]});
        assign pos  = diff[DW-1] ? (~diff + DW'(1)) : diff;
        assign mag_px[i*PIX_W +: PIX_W] = pos[PIX_W-1:0];
    end

endmodule

// File: rtl/sad_row_reduce.sv
module sad_row_reduce
    import sad_pkg::*;
#(
    parameter int LANES = sad_pkg::LANES,
    parameter int PIX_W = sad_pkg::PIX_W,
    parameter int SUM_W = sad_pkg::ROW_SUM_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   take,
    input  row_tag_t               take_tag,
    input  logic [LANES*PIX_W-1:0] mag_px,
    output logic                   st_valid,
    output row_tag_t               st_tag,
    output logic [SUM_W-1:0]       st_sum
);

    localparam int LEVELS  = $clog2(LANES);
    localparam int ROW_MAX = LANES * ((1 << PIX_W) - 1);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N = LANES >> l;
        logic [SUM_W-1:0] s [N];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_i
                assign s[i] = SUM_W'(mag_px[i*PIX_W +: PIX_W]);
            end
        end else begin : g_add
            for (genvar i = 0; i < N; i++) begin : g_i
                assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
            end
        end
    end

    logic [SUM_W-1:0] row_total;
    assign row_total = g_lvl[LEVELS].s[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st_tag   <= '0;
            st_sum   <= '0;
        end else begin
            st_valid <= take;
            if (take) begin
                st_tag <= take_tag;
                st_sum <= row_total;
            end
        end
    end

    // R2: a registered row total never exceeds sixteen full-scale lanes
    a_r2_row_bound: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (32'(st_sum) <= ROW_MAX));

endmodule

// File: rtl/sad_issue_ctrl.sv
module sad_issue_ctrl
    import sad_pkg::*;
#(
    parameter int MAX_ROWS = sad_pkg::MAX_ROWS,
    parameter int CNT_W    = sad_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic [CNT_W-1:0] in_rows,
    input  logic             res_ack,
    input  logic             st_valid,
    input  row_tag_t         st_tag,
    output logic             in_ready,
    output logic             take,
    output row_tag_t         take_tag
);

    logic             open_blk;
    logic [CNT_W-1:0] row_lim;
    logic [CNT_W-1:0] rows_seen;
    logic             res_pend;
    logic             fire;
    logic             tail_busy;
    logic [CNT_W-1:0] req_rows;
    logic             closes_now;

    assign tail_busy  = st_valid && st_tag.closes;
    assign in_ready   = !(tail_busy || res_pend);
    assign fire       = in_valid && in_ready;
    assign req_rows   = legal_rows(in_rows);
    assign closes_now = in_start ? (req_rows == CNT_W'(1))
                                 : (rows_seen + CNT_W'(1) == row_lim);

    assign take           = fire && (in_start || open_blk);
    assign take_tag.opens  = in_start;
    assign take_tag.closes = closes_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_blk  <= 1'b0;
            row_lim   <= CNT_W'(1);
            rows_seen <= '0;
        end else if (fire && in_start) begin
            row_lim   <= req_rows;
            rows_seen <= CNT_W'(1);
            open_blk  <= !closes_now;
        end else if (fire && open_blk) begin
            rows_seen <= rows_seen + CNT_W'(1);
            if (closes_now)
                open_blk <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_pend <= 1'b0;
        else if (tail_busy)
            res_pend <= 1'b1;
        else if (res_ack)
            res_pend <= 1'b0;
    end

    // R5: an open block has always seen fewer rows than its legal limit
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
        open_blk |-> (rows_seen < row_lim) && (row_lim <= CNT_W'(MAX_ROWS)));

    // R7: nothing is accepted while a finished result waits for acknowledge
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        res_pend |-> !in_ready);

endmodule

// File: rtl/sad_accum.sv
module sad_accum
    import sad_pkg::*;
#(
    parameter int SUM_W = sad_pkg::ROW_SUM_W,
    parameter int ACC_W = sad_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  row_tag_t         st_tag,
    input  logic [SUM_W-1:0] st_sum,
    output logic [ACC_W-1:0] acc,
    output logic             done
);

    logic [ACC_W-1:0] row_ext;
    assign row_ext = ACC_W'(st_sum);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= st_valid && st_tag.closes;
            if (st_valid)
                acc <= st_tag.opens ? row_ext : acc + row_ext;
        end
    end

    // R4: adding a row to an open block never makes the total smaller
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_tag.opens) |=> (acc >= $past(acc)));

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sad_row_engine.sv
module sad_row_engine
    import sad_pkg::*;
#(
    parameter int LANES    = sad_pkg::LANES,
    parameter int PIX_W    = sad_pkg::PIX_W,
    parameter int MAX_ROWS = sad_pkg::MAX_ROWS
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic                                 in_start,
    input  logic [$clog2(MAX_ROWS+1)-1:0]        in_rows,
    input  logic [LANES*PIX_W-1:0]               in_cur,
    input  logic [LANES*PIX_W-1:0]               in_ref,
    input  logic                                 res_ack,
    output logic                                 done,
    output logic [PIX_W+$clog2(LANES)+$clog2(MAX_ROWS)-1:0] sad_total
);

    localparam int CW = $clog2(MAX_ROWS + 1);
    localparam int SW = PIX_W + $clog2(LANES);
    localparam int AW = SW + $clog2(MAX_ROWS);

    logic [LANES*PIX_W-1:0] mag_px;
    logic                   take;
    row_tag_t               take_tag;
    logic                   st_valid;
    row_tag_t               st_tag;
    logic [SW-1:0]          st_sum;

    sad_lane_absdiff #(.LANES(LANES), .PIX_W(PIX_W)) u_absdiff (
        .cur_px (in_cur),
        .ref_px (in_ref),
        .mag_px (mag_px)
    );

    sad_issue_ctrl #(.MAX_ROWS(MAX_ROWS), .CNT_W(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_rows  (in_rows),
        .res_ack  (res_ack),
        .st_valid (st_valid),
        .st_tag   (st_tag),
        .in_ready (in_ready),
        .take     (take),
        .take_tag (take_tag)
    );

    sad_row_reduce #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SW)) u_reduce (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .take_tag (take_tag),
        .mag_px   (mag_px),
        .st_valid (st_valid),
        .st_tag   (st_tag),
        .st_sum   (st_sum)
    );

    sad_accum #(.SUM_W(SW), .ACC_W(AW)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .st_valid (st_valid),
        .st_tag   (st_tag),
        .st_sum   (st_sum),
        .acc      (sad_total),
        .done     (done)
    );

endmodule

// File: tb/sad_row_engine_bench.sv
module sad_row_engine_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_start = 1'b0;
    logic [4:0]   in_rows = 5'd0;
    logic [127:0] in_cur = '0;
    logic [127:0] in_ref = '0;
    logic         res_ack = 1'b1;
    logic         done;
    logic [15:0]  sad_total;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sad_row_engine u_sad_row_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_start(in_start), .in_rows(in_rows), .in_cur(in_cur), .in_ref(in_ref),
        .res_ack(res_ack), .done(done), .sad_total(sad_total)
    );

    function automatic int row_sad(input logic [127:0] a, input logic [127:0] b);
        int s = 0;
        for (int i = 0; i < 16; i++) begin
            int d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
            s += (d < 0) ? -d : d;
        end
        return s;
    endfunction

    function automatic logic [127:0] rnd_row();
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'($urandom);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one issue at a falling edge once ready; returns after the accepting edge.
    task automatic send_row(input logic st, input logic [4:0] rows,
                            input logic [127:0] c, input logic [127:0] r);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_start = st; in_rows = rows; in_cur = c; in_ref = r; in_valid = 1'b1;
        @(posedge clk);
        #2 in_valid = 1'b0; in_start = 1'b0;
    endtask

    // Random block of n rows; expected sum pushed to the scoreboard when push is set.
    task automatic run_block(input int n, input logic [4:0] cfg, input bit push);
        int s = 0;
        logic [127:0] c [16];
        logic [127:0] r [16];
        for (int k = 0; k < n; k++) begin
            c[k] = rnd_row(); r[k] = rnd_row(); s += row_sad(c[k], r[k]);
        end
        if (push) exp_q.push_back(s);
        for (int k = 0; k < n; k++) send_row(k == 0, cfg, c[k], r[k]);
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    // Scoreboard monitor: every done pops one expected block sum (R6).
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R6 unexpected done actual=%0d expected=none", sad_total);
            end else begin
                check("R6 block sum at done", int'(sad_total), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b;
        int hold;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R10 in_ready after reset", int'(in_ready), 1);
        check("R10 done after reset", int'(done), 0);
        check("R10 sad_total after reset", int'(sad_total), 0);

        // R1: single lane differences in both directions, lane position 5
        a = '0; b = '0; a[5*8 +: 8] = 8'd10; b[5*8 +: 8] = 8'd200;
        exp_q.push_back(190);
        send_row(1'b1, 5'd1, a, b);
        drain();
        check("R1 cur<ref lane magnitude", int'(sad_total), 190);
        a = '0; b = '0; a[15*8 +: 8] = 8'd255; b[0 +: 8] = 8'd7;
        exp_q.push_back(262);
        send_row(1'b1, 5'd1, a, b);
        drain();
        check("R1 R3 top and bottom lanes, fresh total", int'(sad_total), 262);

        // R4: worst case 16 rows of 255 vs 0
        exp_q.push_back(65280);
        for (int k = 0; k < 16; k++) send_row(k == 0, 5'd16, {16{8'hFF}}, '0);
        drain();
        check("R4 full-scale block no wrap", int'(sad_total), 65280);

        // R2 R3: random blocks of several lengths back to back
        for (int n = 1; n <= 16; n += 3) run_block(n, 5'(n), 1'b1);
        run_block(16, 5'd16, 1'b1);
        drain();

        // R5: clamped row counts
        run_block(1, 5'd0, 1'b1);
        drain();
        run_block(16, 5'd31, 1'b1);
        drain();

        // R6: exact timing of done for a one-row block
        a = rnd_row(); b = rnd_row();
        exp_q.push_back(row_sad(a, b));
        send_row(1'b1, 5'd1, a, b);
        @(negedge clk);
        check("R6 done not yet one edge after accept", int'(done), 0);
        check("R7 in_ready low after last row", int'(in_ready), 0);
        @(negedge clk);
        check("R6 done high two edges after accept", int'(done), 1);
        @(negedge clk);
        check("R6 done falls after one cycle", int'(done), 0);
        check("R6 sad_total holds", int'(sad_total), row_sad(a, b));

        // R7: no acknowledge keeps the input closed
        res_ack = 1'b0;
        a = rnd_row(); b = rnd_row();
        exp_q.push_back(row_sad(a, b));
        send_row(1'b1, 5'd1, a, b);
        repeat (5) @(negedge clk);
        check("R7 in_ready low while unacknowledged", int'(in_ready), 0);
        res_ack = 1'b1;
        @(negedge clk);
        check("R7 in_ready back one edge after ack", int'(in_ready), 1);

        // R8: stray row outside a block is ignored
        hold = int'(sad_total);
        send_row(1'b0, 5'd3, {16{8'hFF}}, '0);
        drain();
        check("R8 stray row leaves total", int'(sad_total), hold);

        // R9: restart abandons an open block
        run_block(2, 5'd4, 1'b0);
        run_block(2, 5'd2, 1'b1);
        drain();
        check("R9 queue empty after restart", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule